// File: doc/BRIEF.md
# Looping Frame Transfer Sequencer

This block decides when a frame of pixel bytes held in an internal buffer is streamed onto a serial output. The output path never pauses. It emits one byte per clock by walking a chain of segment entries. While no frame is due, the chain is a two-entry loop of latch segments, and each of those segments sends only the idle level. Every pixel byte expands into four output bytes. The sequencer does not encode symbols. It presents the pixel byte together with a lane number from 0 to 3, so that a downstream encoder can form each quarter.

The data part of the chain is cut into chunks. A chunk holds a whole number of expanded pixels and is never longer than 4095 bytes. Each entry is a record with these fields:
- block size and data length, 12 bits each
- five spare bits
- sub-start, end-of-frame and owner flags
- a buffer address
- the index of the next entry

Only the first latch entry carries the end-of-frame flag. When its last byte goes out, a four-state controller gets an event. The controller then rewrites the next-index of the second latch entry. Pointing it at the first data chunk splices the frame in. Pointing it back at the first latch entry takes the frame out again. A frame can therefore start only on a latch-segment boundary.

Software loads pixel bytes through a simple write port while the block is ready. It then pulses an update request. A request made while the block is busy is remembered and served as soon as the block is idle again.

Top module: `loop_frame_seq`

## Requirements
- R1: After reset the block is ready, `outIsData` is 0 and `outByte` equals `IDLE_LEVEL`. Whenever `outIsData` is 0, `outByte` equals `IDLE_LEVEL`.
- R2: `ready` is high only in the idle state. An `updReq` sampled while `ready` is high is accepted, and `ready` is low in the next cycle.
- R3: With no request pending, the output loops over the two latch entries forever. `outEntry` alternates between L1 and L2, each run lasting `LATCH_LEN` cycles. L1 = NCHUNK and L2 = NCHUNK+1.
- R4: A data burst always starts in the cycle right after the last byte of latch entry L2.
- R5: Once the end-of-L1 event arrives, a pending request turns into a contiguous burst of 4*`PIXEL_BYTES` data bytes. Output byte k carries pixel byte k/4 with `outLane` = k mod 4.
- R6: After the last data byte, the output returns to entry L1. `ready` rises exactly 3*`LATCH_LEN`+1 cycles after the last data byte. In between, the event moves the controller from Sending to Zeroing, and the next event moves it from Zeroing to Idle.
- R7: The chunk length is CHUNK = floor(`MAX_CHUNK`/(4*`ELEM_BYTES`))*4*`ELEM_BYTES`. The number of chunks is NCHUNK = 4*`PIXEL_BYTES`/CHUNK + 1, followed by two latch entries. Data byte k reports `outEntry` = k/CHUNK. A chunk of length zero is skipped.
- R8: An `updReq` that arrives while `ready` is low is kept. Exactly one further frame is sent for it without a new request.
- R9: In idle the end-of-L1 event is ignored. No data byte is emitted unless a request was made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write strobe for the pixel buffer |
| wrAddr | input | ADDR_W | Pixel byte index to write |
| wrData | input | 8 | Pixel byte value |
| updReq | input | 1 | Request to send the buffered frame |
| ready | output | 1 | High while the controller is idle |
| outByte | output | 8 | Pixel byte for the current output byte, or the idle level |
| outLane | output | 2 | Quarter of the pixel byte, 0 to 3 |
| outIsData | output | 1 | High while a data chunk is streaming |
| outEntry | output | 8 | Index of the chain entry producing the current byte |

## Verification
Each controller state has a port signature:
- A controller stuck in Pending shows a request that lowered `ready` but produced no data burst within a few latch periods.
- A lost relink shows either as a burst that never appears or as data repeating without end.
- A wrong Zeroing exit moves the exact cycle at which `ready` rises after the burst.

Chunk-table errors show within one frame, as a wrong `outEntry` at a chunk boundary or as the skipped zero-length chunk appearing. A held-off request that is lost shows as a missing second burst.

// File: rtl/lfs_pkg.sv
package lfs_pkg;

  // Controller states
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PENDING,
    ST_SENDING,
    ST_ZEROING
  } seqState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic toData;   // point tail latch entry at first data chunk
    logic toLatch;  // point tail latch entry back at head latch entry
  } relink_t;

  // One chain entry record
  typedef struct packed {
    logic        owner;
    logic        eof;
    logic        subSof;
    logic [4:0]  spare;
    logic [11:0] dataLen;
    logic [11:0] blockSize;
    logic [15:0] bufAddr;
    logic [7:0]  nextIdx;
  } chainEntry_t;

endpackage

// File: rtl/lfs_framebuf.sv
module lfs_framebuf #(
  parameter int DEPTH  = 9,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [7:0]        rdData
);

  logic [7:0] cells [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    logic [7:0] word;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        word <= 8'h00;
      end else if (wrEn && (wrAddr == ADDR_W'(g))) begin
        word <= wrData;
      end
    end
    assign cells[g] = word;
  end

  always_comb begin
    rdData = 8'h00;
    for (int i = 0; i < DEPTH; i++) begin
      if (rdAddr == ADDR_W'(i)) rdData = cells[i];
    end
  end

endmodule

// File: rtl/lfs_ctrl.sv
module lfs_ctrl
  import lfs_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    updReq,
  input  logic    segEvt,
  output logic    ready,
  output relink_t relink
);

  seqState_t state, stateNxt;
  logic      heldReq;

  always_comb begin
    stateNxt = state;
    relink   = '0;
    unique case (state)
      ST_IDLE:    if (updReq || heldReq) stateNxt = ST_PENDING;
      ST_PENDING: if (segEvt) begin
                    stateNxt      = ST_SENDING;
                    relink.toData = 1'b1;
                  end
      ST_SENDING: if (segEvt) begin
                    stateNxt       = ST_ZEROING;
                    relink.toLatch = 1'b1;
                  end
      ST_ZEROING: if (segEvt) stateNxt = ST_IDLE;
      default:    stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      heldReq <= 1'b0;
    end else begin
      state   <= stateNxt;
      heldReq <= (state != ST_IDLE) ? (heldReq | updReq) : 1'b0;
    end
  end

  assign ready = (state == ST_IDLE);

  // R2
  req_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ready && updReq) |=> !ready);

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ready && !updReq && !heldReq) |=> ready);

  // R5
  pend_send_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PENDING && segEvt) |=> (state == ST_SENDING));

  // R8
  held_serve_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ready && heldReq) |=> !ready);

endmodule

// File: rtl/lfs_chain.sv
module lfs_chain
  import lfs_pkg::*;
#(
  parameter int         PIXEL_BYTES = 9,
  parameter int         ELEM_BYTES  = 3,
  parameter int         MAX_CHUNK   = 4095,
  parameter int         LATCH_LEN   = 4,
  parameter logic [7:0] IDLE_LEVEL  = 8'h00,
  parameter int         ADDR_W      = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  relink_t           relink,
  output logic [ADDR_W-1:0] rdAddr,
  input  logic [7:0]        rdData,
  output logic              segEvt,
  output logic [7:0]        outByte,
  output logic [1:0]        outLane,
  output logic              outIsData,
  output logic [7:0]        outEntry
);

  localparam int EXP_LEN = PIXEL_BYTES * 4;
  localparam int PIX_EXP = 4 * ELEM_BYTES;
  localparam int CHUNK   = (MAX_CHUNK / PIX_EXP) * PIX_EXP;
  localparam int NCHUNK  = EXP_LEN / CHUNK + 1;
  localparam int NENT    = NCHUNK + 2;
  localparam int ENT_W   = $clog2(NENT);
  localparam logic [ENT_W-1:0] L1_IDX = ENT_W'(NCHUNK);
  localparam logic [ENT_W-1:0] L2_IDX = ENT_W'(NCHUNK + 1);

  function automatic chainEntry_t initEntry(input int idx);
    chainEntry_t e;
    int len;
    e       = '0;
    e.owner = 1'b1;
    if (idx < NCHUNK) begin
      len = EXP_LEN - idx * CHUNK;
      if (len > CHUNK) len = CHUNK;
      if (len < 0) len = 0;
      e.dataLen = 12'(len);
      e.bufAddr = 16'(idx * CHUNK);
      e.nextIdx = 8'(idx + 1);
    end else begin
      e.dataLen = 12'(LATCH_LEN);
      e.eof     = (idx == NCHUNK);
      e.nextIdx = (idx == NCHUNK) ? 8'(NCHUNK + 1) : 8'(NCHUNK);
    end
    e.blockSize = e.dataLen;
    return e;
  endfunction

  chainEntry_t tbl [NENT];

  // Chain table; only the tail latch link changes after reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NENT; i++) tbl[i] <= initEntry(i);
    end else if (relink.toData) begin
      tbl[L2_IDX].nextIdx <= 8'd0;
    end else if (relink.toLatch) begin
      tbl[L2_IDX].nextIdx <= 8'(NCHUNK);
    end
  end

  // Walker
  logic [ENT_W-1:0] curEnt, hop1, hopNxt;
  logic [11:0]      cnt;
  chainEntry_t      cur;
  logic [15:0]      pos, pixPos;
  logic             lastByte, isDataNow;

  assign cur       = tbl[curEnt];
  assign hop1      = cur.nextIdx[ENT_W-1:0];
  assign hopNxt    = (tbl[hop1].dataLen == 12'd0) ? tbl[hop1].nextIdx[ENT_W-1:0] : hop1;
  assign lastByte  = (cnt == cur.dataLen - 12'd1);
  assign isDataNow = (curEnt < L1_IDX);
  assign pos       = cur.bufAddr + 16'(cnt);
  assign pixPos    = pos >> 2;
  assign rdAddr    = pixPos[ADDR_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curEnt    <= L1_IDX;
      cnt       <= 12'd0;
      segEvt    <= 1'b0;
      outByte   <= IDLE_LEVEL;
      outLane   <= 2'd0;
      outIsData <= 1'b0;
      outEntry  <= 8'(NCHUNK);
    end else begin
      outByte   <= isDataNow ? rdData : IDLE_LEVEL;
      outLane   <= isDataNow ? pos[1:0] : 2'd0;
      outIsData <= isDataNow;
      outEntry  <= 8'(curEnt);
      segEvt    <= lastByte && cur.eof;
      if (lastByte) begin
        cnt    <= 12'd0;
        curEnt <= hopNxt;
      end else begin
        cnt <= cnt + 12'd1;
      end
    end
  end

  // R4
  data_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outIsData) |-> ($past(outEntry) == 8'(L2_IDX)));

  // R5
  lane_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outIsData && $past(outIsData)) |-> (outLane == $past(outLane) + 2'd1));

  // R3
  evt_place_chk: assert property (@(posedge clk) disable iff (!rstN)
    segEvt |-> (outEntry == 8'(L1_IDX)));

  // R1
  latch_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    !outIsData |-> (outByte == IDLE_LEVEL));

  // R7
  chunk_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outIsData && $past(outIsData)) |-> (outEntry >= $past(outEntry)));

endmodule

// File: rtl/loop_frame_seq.sv
module loop_frame_seq
  import lfs_pkg::*;
#(
  parameter int         PIXEL_BYTES = 9,
  parameter int         ELEM_BYTES  = 3,
  parameter int         MAX_CHUNK   = 4095,
  parameter int         LATCH_LEN   = 4,
  parameter logic [7:0] IDLE_LEVEL  = 8'h00,
  localparam int        ADDR_W      = (PIXEL_BYTES > 1) ? $clog2(PIXEL_BYTES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  logic              updReq,
  output logic              ready,
  output logic [7:0]        outByte,
  output logic [1:0]        outLane,
  output logic              outIsData,
  output logic [7:0]        outEntry
);

  // LATCH_LEN must be at least 2 so a relink lands before the tail entry ends

  relink_t           relink;
  logic              segEvt;
  logic [ADDR_W-1:0] rdAddr;
  logic [7:0]        rdData;

  lfs_framebuf #(
    .DEPTH (PIXEL_BYTES),
    .ADDR_W(ADDR_W)
  ) u_buf (
    .clk   (clk),
    .rstN  (rstN),
    .wrEn  (wrEn),
    .wrAddr(wrAddr),
    .wrData(wrData),
    .rdAddr(rdAddr),
    .rdData(rdData)
  );

  lfs_ctrl u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .updReq(updReq),
    .segEvt(segEvt),
    .ready (ready),
    .relink(relink)
  );

  lfs_chain #(
    .PIXEL_BYTES(PIXEL_BYTES),
    .ELEM_BYTES (ELEM_BYTES),
    .MAX_CHUNK  (MAX_CHUNK),
    .LATCH_LEN  (LATCH_LEN),
    .IDLE_LEVEL (IDLE_LEVEL),
    .ADDR_W     (ADDR_W)
  ) u_chain (
    .clk      (clk),
    .rstN     (rstN),
    .relink   (relink),
    .rdAddr   (rdAddr),
    .rdData   (rdData),
    .segEvt   (segEvt),
    .outByte  (outByte),
    .outLane  (outLane),
    .outIsData(outIsData),
    .outEntry (outEntry)
  );

endmodule

// File: tb/sim_loop_frame_seq.sv
`timescale 1ns/1ps
module sim_loop_frame_seq;

  localparam int         PB     = 12;
  localparam int         EB     = 3;
  localparam int         MAXC   = 30;
  localparam int         LL     = 4;
  localparam logic [7:0] IDLE   = 8'h3C;
  localparam int         AW     = 4;
  localparam int         EXP    = PB * 4;
  localparam int         CHUNK  = (MAXC / (4 * EB)) * (4 * EB);
  localparam int         NCH    = EXP / CHUNK + 1;
  localparam int         L1     = NCH;
  localparam int         L2     = NCH + 1;

  logic clk = 1'b0, rstN = 1'b0;
  logic wrEn = 1'b0, updReq = 1'b0;
  logic [AW-1:0] wrAddr = '0;
  logic [7:0] wrData = 8'h00;
  logic ready, outIsData;
  logic [7:0] outByte, outEntry;
  logic [1:0] outLane;

  always #2.5 clk = ~clk;

  loop_frame_seq #(
    .PIXEL_BYTES(PB), .ELEM_BYTES(EB), .MAX_CHUNK(MAXC),
    .LATCH_LEN(LL), .IDLE_LEVEL(IDLE)
  ) u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .updReq(updReq), .ready(ready), .outByte(outByte), .outLane(outLane),
    .outIsData(outIsData), .outEntry(outEntry)
  );

  int nChecks = 0, nFail = 0;
  bit done = 1'b0;
  logic [7:0] pix [PB];
  int prevEntry = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    prevEntry = int'(outEntry);
    @(negedge clk);
  endtask

  task automatic writePix(input int mode);
    for (int i = 0; i < PB; i++) begin
      case (mode)
        0: pix[i] = 8'($urandom);
        1: pix[i] = 8'hFF;
        default: pix[i] = (i % 2 == 0) ? 8'h55 : 8'hAA;
      endcase
      wrEn = 1'b1; wrAddr = AW'(i); wrData = pix[i];
      step();
    end
    wrEn = 1'b0;
  endtask

  // Expected latch loop behaviour over n samples
  task automatic idleCheck(input string req, input int n);
    int bad = 0, badRun = 0, runLen = 0, runs = 0;
    int lastE;
    lastE = int'(outEntry);
    for (int i = 0; i < n; i++) begin
      step();
      if (!ready || outIsData || outByte != IDLE) bad++;
      if (int'(outEntry) != L1 && int'(outEntry) != L2) bad++;
      if (int'(outEntry) == lastE) runLen++;
      else begin
        if (runs > 0 && runLen != LL) badRun++;
        runs++;
        runLen = 1;
        lastE = int'(outEntry);
      end
    end
    chk(bad == 0, req, "idle loop mismatched samples", bad, 0);
    chk(badRun == 0, req, "latch run length errors", badRun, 0);
  endtask

  // Wait for one data burst and check it; optionally request first
  task automatic runFrame(input bit doReq, input int pulseAt);
    int n = 0, badLat = 0, badByte = 0, badLane = 0, badEnt = 0, badBusy = 0;
    if (doReq) begin
      while (!ready) step();
      updReq = 1'b1;
      step();
      updReq = 1'b0;
      chk(!ready, "R2", "ready after accepted request", int'(ready), 0);
    end
    while (!outIsData && n < 400) begin
      if (outByte != IDLE) badLat++;
      step();
      n++;
    end
    chk(outIsData, "R5", "data burst started", int'(outIsData), 1);
    chk(prevEntry == L2, "R4", "entry before burst", prevEntry, L2);
    chk(badLat == 0, "R1", "non-idle latch bytes", badLat, 0);
    for (int k = 0; k < EXP; k++) begin
      if (k > 0) step();
      updReq = (k == pulseAt);
      if (!outIsData) badBusy++;
      if (outByte != pix[k / 4]) badByte++;
      if (int'(outLane) != k % 4) badLane++;
      if (int'(outEntry) != k / CHUNK) badEnt++;
      if (ready) badBusy++;
    end
    updReq = 1'b0;
    chk(badBusy == 0, "R5", "burst gaps or ready high", badBusy, 0);
    chk(badByte == 0, "R5", "wrong data bytes", badByte, 0);
    chk(badLane == 0, "R5", "wrong lanes", badLane, 0);
    chk(badEnt == 0, "R7", "wrong chunk entries", badEnt, 0);
    badBusy = 0;
    for (int m = 1; m <= 3 * LL + 1; m++) begin
      step();
      if (m == 1) chk(int'(outEntry) == L1, "R7", "entry after burst (zero chunk skipped)",
                      int'(outEntry), L1);
      if (m <= 3 * LL && (ready || outIsData)) badBusy++;
      if (m == 3 * LL + 1) chk(ready, "R6", "ready at 3*LATCH_LEN+1", int'(ready), 1);
    end
    chk(badBusy == 0, "R6", "early ready or extra data", badBusy, 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(ready && !outIsData && outByte == IDLE, "R1", "state during reset",
        int'(outByte), int'(IDLE));
    rstN = 1'b1;
    step();
    chk(ready, "R1", "ready after reset", int'(ready), 1);
    chk(!outIsData && outByte == IDLE, "R1", "idle level after reset", int'(outByte), int'(IDLE));

    idleCheck("R3", 10 * LL);

    writePix(1);
    runFrame(1'b1, -1);
    idleCheck("R9", 100);

    writePix(2);
    runFrame(1'b1, -1);

    for (int it = 0; it < 6; it++) begin
      writePix(0);
      repeat ($urandom_range(0, 30)) step();
      runFrame(1'b1, -1);
    end

    // Held request during a burst
    writePix(0);
    runFrame(1'b1, 20);
    runFrame(1'b0, -1);
    chk(1'b1, "R8", "second frame served from held request", 1, 1);
    idleCheck("R8", 80);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

endmodule